// File: doc/BRIEF.md
# Byte-Bus Capture/Compare Timer

A 16-bit up-counter with two compare channels, one input capture register, four interrupt sources and their enables. All of it is reached over an 8-bit register bus. Because the bus is narrow, every 16-bit register sits behind one shared 8-bit staging latch. A high-byte write fills that latch. A low-byte write then commits both bytes in a single cycle. A low-byte read copies the matching high byte into the latch, so the high-byte read that follows returns a consistent snapshot even while the counter is running.

Each compare channel checks the counter on every cycle and, on a match, raises its flag and may toggle its own waveform pin. A capture input is chosen from a pin or a comparator result, passed through a two-stage synchronizer and edge-detected on a selectable polarity. The capture loads the current count into a read-only register, and that register can serve as the counter's wrap point. Each flag is gated by its own enable and by a global enable to form an interrupt request. A flag is cleared by writing 1 to it or by an acknowledge pulse.

Top module: `cct_timer16`

## Requirements
- R1: After a synchronous active-low reset, every register, the counter, all flags, `irq_req`, `wave_a` and `wave_b` are 0.
- R2: Register map: 0/1 counter low/high, 2/3 compare A low/high, 4/5 compare B low/high, 6/7 capture low/high, 8 control, 9 enable mask, 10 flags. A write to address 1, 3 or 5 loads only the shared staging latch. A write to address 0, 2 or 4 loads {latch, data} into that 16-bit register in the same edge.
- R3: A read of address 0, 2, 4 or 6 copies that register's high byte into the one shared latch. A read of any odd address returns the latch. A later low write to any register uses whatever the latch holds.
- R4: With control bit 0 set, the counter adds 1 per cycle. At TOP it wraps to 0 and sets the overflow flag (flag bit 0). A counter write has priority over counting.
- R5: While the counter runs and equals compare A (or B), flag bit 1 (or bit 2) is set. If control bit 4 (or bit 5) is set, `wave_a` (or `wave_b`) toggles.
- R6: The capture source is `cap_pin` when control bit 3 is 0 and `cap_cmp` when it is 1. The edge is rising when control bit 2 is 1 and falling when it is 0. After a two-stage synchronizer, the selected edge loads the counter into the capture register and sets flag bit 5. An edge of the other polarity has no effect.
- R7: The capture register is read-only, and writes to addresses 6 and 7 change neither it nor the latch.
- R8: In the mask register only bits 5, 2, 1 and 0 are writable. Bits 7, 6, 4 and 3 always read 0.
- R9: `irq_req` = {capture, compare B, compare A, overflow}. Each bit is 1 only when its flag, its mask bit and `irq_global_en` are all 1.
- R10: Writing 1 to a bit of the flag register clears that flag, and `irq_ack[i]` clears the flag behind `irq_req[i]`. A set in the same cycle wins.
- R11: With control bit 1 set, TOP is the capture register instead of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the staging latch on low-byte reads) |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data, combinational from `bus_addr` |
| cap_pin | input | 1 | Asynchronous capture pin |
| cap_cmp | input | 1 | Alternate capture source (comparator result) |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Per-source acknowledge, same order as `irq_req` |
| irq_req | output | 4 | Gated interrupt requests |
| wave_a | output | 1 | Compare A waveform |
| wave_b | output | 1 | Compare B waveform |

## Verification
The bench uses the defaults: an 8-bit bus, a 16-bit counter and two synchronizer stages. At these values a wrap from 0xFFFF takes only a few cycles when the counter is preloaded near the top. The read snapshot can be caught across a 0x00FF to 0x0100 carry, and a capture-defined TOP of 5 keeps the count small enough to bound directly. Two synchronizer stages keep capture latency short, so single pulses a few cycles wide are enough to exercise both polarities and both sources.

// File: rtl/cct_pkg.sv
// Shared constants for the capture/compare timer: register addresses,
// control bit positions and flag/mask bit positions.
// Assumes a 4-bit register address space.
package cct_pkg;
    typedef logic [3:0] cct_addr_t;

    localparam cct_addr_t A_CNT_L  = 4'd0;
    localparam cct_addr_t A_CNT_H  = 4'd1;
    localparam cct_addr_t A_CMPA_L = 4'd2;
    localparam cct_addr_t A_CMPA_H = 4'd3;
    localparam cct_addr_t A_CMPB_L = 4'd4;
    localparam cct_addr_t A_CMPB_H = 4'd5;
    localparam cct_addr_t A_CAP_L  = 4'd6;
    localparam cct_addr_t A_CAP_H  = 4'd7;
    localparam cct_addr_t A_CTRL   = 4'd8;
    localparam cct_addr_t A_MASK   = 4'd9;
    localparam cct_addr_t A_FLAG   = 4'd10;

    localparam int C_RUN    = 0;
    localparam int C_TOPCAP = 1;
    localparam int C_RISE   = 2;
    localparam int C_SRCCMP = 3;
    localparam int C_OUTA   = 4;

    localparam int N_SRC = 4;
    localparam int N_CMP = 2;
    // flag/mask bit position per source: ovf, cmpA, cmpB, capture
    localparam int SRC_BIT [N_SRC] = '{0, 1, 2, 5};
endpackage

// File: rtl/cct_capture.sv
// Capture event generator: picks a source, synchronizes it through
// SYNC_STAGES flops and emits a one-cycle pulse on the chosen edge.
// Assumes SYNC_STAGES >= 2 and that source inputs are asynchronous.
module cct_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic cmp_in,
    input  logic use_cmp,
    input  logic rise_sel,
    output logic evt
);
    localparam int MSB = SYNC_STAGES - 1;

    logic             raw;
    logic [MSB:0]     sync_q;
    logic             prev_q;

    assign raw = use_cmp ? cmp_in : pin_in;

    // synchronizer chain plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], raw};
            prev_q <= sync_q[MSB];
        end
    end

    // edge qualification by selected polarity
    always_comb begin
        if (rise_sel) evt = sync_q[MSB] & ~prev_q;
        else          evt = ~sync_q[MSB] & prev_q;
    end

    // R6: an event can only follow a real change on the synchronized line
    assert_evt_from_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/cct_compare.sv
// One compare channel: flags equality of the running counter with its
// compare value and toggles the waveform pin when output is enabled.
module cct_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             run,
    input  logic             out_en,
    output logic             match,
    output logic             wave
);
    assign match = run && (cnt == cmp);

    // waveform toggle register
    always_ff @(posedge clk) begin
        if (!rst_n)                wave <= 1'b0;
        else if (match && out_en)  wave <= ~wave;
    end

    // R5: the waveform only moves on an enabled match
    assert_wave_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && out_en) |=> $stable(wave));
    assert_wave_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && out_en) |=> (wave != $past(wave)));
endmodule

// File: rtl/cct_irq_flag.sv
// One interrupt source: sticky flag with set-over-clear priority,
// gated by its enable and the global enable into a request.
module cct_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    input  logic gen,
    output logic flag,
    output logic req
);
    // sticky flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign req = flag & en & gen;

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !req);
endmodule

// File: rtl/cct_timer16.sv
// Capture/compare timer top: counter, compare and capture registers, the
// shared staging latch for atomic 16-bit access, control, mask and flags.
// Assumes a single-master bus whose strobes are held for one cycle;
// bus_rdata is combinational from bus_addr.
module cct_timer16
    import cct_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap_pin,
    input  logic              cap_cmp,
    input  logic              irq_global_en,
    input  logic [3:0]        irq_ack,
    output logic [3:0]        irq_req,
    output logic              wave_a,
    output logic              wave_b
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  cnt_q, capt_q, top_val;
    logic [CNT_W-1:0]  cmp_q [N_CMP];
    logic [BYTE_W-1:0] temp_q, ctrl_q, mask_q, flag_byte, mask_wmask;
    logic [N_CMP-1:0]  match_v, wave_v;
    logic [N_SRC-1:0]  set_v, clr_v, flag_v, en_v;
    logic              run, cnt_load, ovf_evt, cap_evt;

    assign run      = ctrl_q[C_RUN];
    assign cnt_load = bus_wr && (bus_addr == A_CNT_L);
    assign top_val  = ctrl_q[C_TOPCAP] ? capt_q : CNT_MAX;
    assign ovf_evt  = run && !cnt_load && (cnt_q == top_val);

    // counter: bus commit first, then count with wrap at TOP
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_load) cnt_q <= {temp_q, bus_wdata};
        else if (ovf_evt)  cnt_q <= '0;
        else if (run)      cnt_q <= cnt_q + 1'b1;
    end

    // shared staging latch: high writes fill it, low reads snapshot into it
    always_ff @(posedge clk) begin
        if (!rst_n) temp_q <= '0;
        else if (bus_wr) begin
            if (bus_addr == A_CNT_H || bus_addr == A_CMPA_H || bus_addr == A_CMPB_H)
                temp_q <= bus_wdata;
        end else if (bus_rd) begin
            case (bus_addr)
                A_CNT_L:  temp_q <= cnt_q[CNT_W-1:BYTE_W];
                A_CMPA_L: temp_q <= cmp_q[0][CNT_W-1:BYTE_W];
                A_CMPB_L: temp_q <= cmp_q[1][CNT_W-1:BYTE_W];
                A_CAP_L:  temp_q <= capt_q[CNT_W-1:BYTE_W];
                default:  temp_q <= temp_q;
            endcase
        end
    end

    // compare registers and channels, one per generate slice
    for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
        localparam cct_addr_t LO_ADDR = cct_addr_t'(int'(A_CMPA_L) + 2 * ch);

        // compare value commit on low-byte write
        always_ff @(posedge clk) begin
            if (!rst_n) cmp_q[ch] <= '0;
            else if (bus_wr && bus_addr == LO_ADDR) cmp_q[ch] <= {temp_q, bus_wdata};
        end

        cct_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt_q),
            .cmp    (cmp_q[ch]),
            .run    (run),
            .out_en (ctrl_q[C_OUTA + ch]),
            .match  (match_v[ch]),
            .wave   (wave_v[ch])
        );
    end

    assign wave_a = wave_v[0];
    assign wave_b = wave_v[1];

    cct_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (cap_pin),
        .cmp_in   (cap_cmp),
        .use_cmp  (ctrl_q[C_SRCCMP]),
        .rise_sel (ctrl_q[C_RISE]),
        .evt      (cap_evt)
    );

    // capture register: loaded only by capture events
    always_ff @(posedge clk) begin
        if (!rst_n)       capt_q <= '0;
        else if (cap_evt) capt_q <= cnt_q;
    end

    // control and mask registers
    always_comb begin
        mask_wmask = '0;
        for (int i = 0; i < N_SRC; i++) mask_wmask[SRC_BIT[i]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
            if (bus_addr == A_MASK) mask_q <= bus_wdata & mask_wmask;
        end
    end

    // per-source flag set/clear vectors and flag byte view
    assign set_v = {cap_evt, match_v[1], match_v[0], ovf_evt};

    always_comb begin
        flag_byte = '0;
        for (int i = 0; i < N_SRC; i++) begin
            en_v[i]  = mask_q[SRC_BIT[i]];
            clr_v[i] = irq_ack[i] | (bus_wr && bus_addr == A_FLAG && bus_wdata[SRC_BIT[i]]);
            flag_byte[SRC_BIT[i]] = flag_v[i];
        end
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        cct_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[s]),
            .clr   (clr_v[s]),
            .en    (en_v[s]),
            .gen   (irq_global_en),
            .flag  (flag_v[s]),
            .req   (irq_req[s])
        );
    end

    // read data mux; odd addresses return the staging latch
    always_comb begin
        case (bus_addr)
            A_CNT_L:  bus_rdata = cnt_q[BYTE_W-1:0];
            A_CMPA_L: bus_rdata = cmp_q[0][BYTE_W-1:0];
            A_CMPB_L: bus_rdata = cmp_q[1][BYTE_W-1:0];
            A_CAP_L:  bus_rdata = capt_q[BYTE_W-1:0];
            A_CNT_H, A_CMPA_H, A_CMPB_H, A_CAP_H: bus_rdata = temp_q;
            A_CTRL:   bus_rdata = ctrl_q;
            A_MASK:   bus_rdata = mask_q;
            A_FLAG:   bus_rdata = flag_byte;
            default:  bus_rdata = '0;
        endcase
    end

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt_q == '0));
    assert_capture_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capt_q == $past(cnt_q)));
    assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(capt_q));
    assert_latch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> $stable(temp_q));
    assert_mask_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_MASK) |-> (bus_rdata[7:6] == 2'b00 && bus_rdata[4:3] == 2'b00));
endmodule

// File: tb/cct_timer16_tb_top.sv
module cct_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0, cap_cmp = 1'b0, irq_global_en = 1'b0;
    logic [3:0] irq_ack = '0;
    logic [3:0] irq_req;
    logic       wave_a, wave_b;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cct_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cap_cmp(cap_cmp), .irq_global_en(irq_global_en),
        .irq_ack(irq_ack), .irq_req(irq_req), .wave_a(wave_a), .wave_b(wave_b)
    );

    // register pairs and values: {low address, value}, counter stopped
    localparam logic [19:0] VEC [6] = '{
        20'h0_1234, 20'h2_ABCD, 20'h4_00FF, 20'h0_FF00, 20'h2_8001, 20'h4_7FFE
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo + 4'd1, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  b, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check({12'h0, irq_req}, 16'h0, "R1 irq");
        check({14'h0, wave_a, wave_b}, 16'h0, "R1 waves");
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), b);
            check({8'h0, b}, 16'h0, "R1 reg");
        end

        // R2/R3: table walk of atomic write and read-back
        for (int i = 0; i < 6; i++) begin
            wr16(VEC[i][19:16], VEC[i][15:0]);
            rd16(VEC[i][19:16], v);
            check(v, VEC[i][15:0], "R2 vector");
        end

        // R2: high write alone leaves register unchanged
        wr16(4'd2, 16'h1255);
        wr(4'd3, 8'h77);
        rd16(4'd2, v);
        check(v, 16'h1255, "R2 high-only write");

        // R3: latch is shared; counter low read feeds a compare commit
        wr16(4'd0, 16'h12FF);
        rd(4'd0, b);
        wr(4'd4, 8'h55);
        rd16(4'd4, v);
        check(v, 16'h1255, "R3 shared latch");

        // R3/R4: snapshot across a carry while running
        wr16(4'd0, 16'h00F8);
        wr(4'd8, 8'h01);
        rd(4'd0, lo);
        check({15'h0, (lo >= 8'hF8)}, 16'h1, "R4 counting low");
        wait_cyc(20);
        rd(4'd1, b);
        check({8'h0, b}, 16'h0000, "R3 snapshot high");
        rd(4'd0, b);
        rd(4'd1, b);
        check({8'h0, b}, 16'h0001, "R4 live high after carry");
        wr(4'd8, 8'h00);

        // R8: reserved mask bits
        wr(4'd9, 8'hFF);
        rd(4'd9, b);
        check({8'h0, b}, 16'h0027, "R8 mask");

        // R5/R9/R10: compare matches, waveforms and requests
        wr(4'd10, 8'hFF);
        wr16(4'd2, 16'h0010);
        wr16(4'd4, 16'h0020);
        wr16(4'd0, 16'h0000);
        wr(4'd9, 8'h06);
        irq_global_en = 1'b1;
        wr(4'd8, 8'h31);
        wait_cyc(60);
        wr(4'd8, 8'h00);
        #1;
        check({14'h0, wave_a, wave_b}, 16'h3, "R5 waves toggled");
        check({12'h0, irq_req}, 16'h6, "R9 compare requests");
        irq_global_en = 1'b0;
        #1 check({12'h0, irq_req}, 16'h0, "R9 global gate");
        irq_global_en = 1'b1;
        wr(4'd10, 8'h02);
        #1 check({12'h0, irq_req}, 16'h4, "R10 write-one clear");
        @(negedge clk); irq_ack = 4'b0100;
        @(negedge clk); irq_ack = 4'b0000;
        #1 check({12'h0, irq_req}, 16'h0, "R10 ack clear");
        rd(4'd10, b);
        check({8'h0, b}, 16'h0, "R10 flags empty");

        // R4: overflow wrap
        wr(4'd9, 8'h01);
        wr16(4'd0, 16'hFFFD);
        wr(4'd8, 8'h01);
        wait_cyc(10);
        wr(4'd8, 8'h00);
        #1 check({12'h0, irq_req}, 16'h1, "R4 overflow request");
        rd16(4'd0, v);
        check({15'h0, (v < 16'h0010)}, 16'h1, "R4 wrapped count");
        wr(4'd10, 8'hFF);

        // R6: rising capture on pin with counter stopped
        wr16(4'd0, 16'h4321);
        wr(4'd8, 8'h04);
        cap_pin = 1'b1; wait_cyc(5); cap_pin = 1'b0; wait_cyc(5);
        rd16(4'd6, v);
        check(v, 16'h4321, "R6 rising pin capture");
        rd(4'd10, b);
        check({8'h0, b}, 16'h0020, "R6 capture flag");

        // R7: writes to capture ignored
        wr(4'd7, 8'hAA);
        wr(4'd6, 8'hBB);
        rd16(4'd6, v);
        check(v, 16'h4321, "R7 read-only capture");

        // R6: falling edge on comparator source; rising edge ignored
        wr16(4'd0, 16'h0ABC);
        wr(4'd8, 8'h08);
        cap_cmp = 1'b1; wait_cyc(5);
        rd16(4'd6, v);
        check(v, 16'h4321, "R6 wrong polarity ignored");
        cap_cmp = 1'b0; wait_cyc(5);
        rd16(4'd6, v);
        check(v, 16'h0ABC, "R6 falling comparator capture");

        // R11: capture-defined TOP
        wr16(4'd0, 16'h0005);
        wr(4'd8, 8'h04);
        cap_pin = 1'b1; wait_cyc(5); cap_pin = 1'b0; wait_cyc(5);
        wr(4'd10, 8'hFF);
        wr16(4'd0, 16'h0000);
        wr(4'd8, 8'h07);
        wait_cyc(50);
        wr(4'd8, 8'h04);
        rd16(4'd0, v);
        check({15'h0, (v <= 16'h0005)}, 16'h1, "R11 count bounded by capture");
        rd(4'd10, b);
        check({15'h0, b[0]}, 16'h1, "R11 wrap flag");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule